// File: doc/BRIEF.md
# Two-Wire Debug Mode Select Watcher

This block sits on the target side of a debug port whose clock and data/mode pins are shared by two protocols: a scan-chain protocol and a two-wire serial debug protocol. It samples the data pin on every rising edge of the debug clock and decides which of the two protocols owns the pins. A long unbroken run of ones on the data pin is a line reset. That reset returns both protocol engines to their reset states, and it also arms a 16-bit pattern matcher.

When the armed matcher sees the selection code 0x79E7, sent least-significant bit first, the block hands the pins to the two-wire protocol. It does not declare the link usable yet. A second line reset must follow the code, and only then does the link-ready flag rise. After that point the packet layer checks frame alignment by reading the identification register, which is outside this block. The mode and ready flags are sticky until the synchronous reset. Each completed line reset produces a single-cycle pulse that neighbouring logic uses to reset its own state.

Top module: `dbg_wire_select`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, the outputs after that edge are `wire_mode_o`=0 (scan-chain mode), `link_ready_o`=0 and `line_rst_o`=0.
- R2: `line_rst_o` is high for exactly one cycle, in the cycle after the edge that samples the RUN_LEN-th (default 50) consecutive 1 on `dio_i`. It does not rise earlier.
- R3: A 0 sampled on `dio_i` restarts the run count. A run of RUN_LEN-1 ones, a 0, and then RUN_LEN-1 more ones produces no pulse.
- R4: After a line reset has armed the matcher, the code 0x79E7 sent with bit 0 first sets `wire_mode_o` to 1 in the cycle after its 16th bit is sampled. After only 15 bits of the code, the mode is still 0. Non-matching bits that come after arming leave the matcher armed.
- R5: If no line reset has occurred since the last `rst_i`, the selection code is ignored and `wire_mode_o` stays 0. A different 16-bit value also leaves the mode unchanged.
- R6: After the switch, `link_ready_o` stays 0 until the next completed line reset. It rises in the same cycle as that line reset's `line_rst_o` pulse. Runs of ones shorter than RUN_LEN do not raise it.
- R7: Once set, `wire_mode_o` and `link_ready_o` remain 1 whatever arrives on `dio_i`, until `rst_i`.
- R8: `rst_i` from the ready state clears both flags and disarms the matcher, so a selection code that follows with no new line reset does not switch the mode.
- R9: The run counter saturates. A run of 200 ones yields exactly one `line_rst_o` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck_i | input | 1 | Debug clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| dio_i | input | 1 | Sampled data / mode-select pin |
| wire_mode_o | output | 1 | 1 when the two-wire protocol owns the pins, 0 for scan-chain mode |
| line_rst_o | output | 1 | Single-cycle pulse after each completed line reset |
| link_ready_o | output | 1 | 1 once the post-switch line reset has completed |

## Verification
Two events can land on the same edge: completion of the line reset that follows the selection code, and promotion of the link to ready. The bench sends the code and then exactly RUN_LEN ones. It checks that `link_ready_o` is still low after RUN_LEN-1 ones, and that after the final one both `line_rst_o` and `link_ready_o` read 1 in the same sample. A run that a 0 cuts short must not promote the link, and the bench checks that case separately.

// File: rtl/dws_pkg.sv
package dws_pkg;

  localparam int unsigned DEF_RUN_LEN  = 50;
  localparam int unsigned DEF_CODE_W   = 16;
  localparam logic [15:0] DEF_SEL_CODE = 16'h79E7;

  typedef enum logic [1:0] {
    LS_SCAN     = 2'd0,
    LS_WAIT_RST = 2'd1,
    LS_READY    = 2'd2
  } link_state_e;

  // Next value of a saturating run-of-ones counter.
  function automatic int unsigned run_step(input int unsigned cur,
                                           input logic        bit_in,
                                           input int unsigned cap);
    if (!bit_in)     return 0;
    if (cur >= cap)  return cap;
    return cur + 1;
  endfunction

  // True when this sample is the one that completes a full run.
  function automatic logic run_completes(input int unsigned cur,
                                         input logic        bit_in,
                                         input int unsigned cap);
    return bit_in && (cur + 1 == cap);
  endfunction

endpackage

// File: rtl/dws_run_detect.sv
module dws_run_detect #(
  parameter int unsigned RUN_LEN = dws_pkg::DEF_RUN_LEN
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic dio_i,
  output logic evt_o,
  output logic pulse_o
);
  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);

  logic [CNT_W-1:0] run_q, run_d;
  logic             pulse_q;

  always_comb begin
    run_d = CNT_W'(dws_pkg::run_step(32'(run_q), dio_i, RUN_LEN));
    evt_o = dws_pkg::run_completes(32'(run_q), dio_i, RUN_LEN);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      pulse_q <= evt_o;
    end
  end

  assign pulse_o = pulse_q;

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    rst_i |=> !pulse_o);

  p_single_pulse_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse_o |=> !pulse_o);

  p_pulse_after_one_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse_o |-> $past(dio_i));

  p_run_bounded_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(pulse_o) && $past(dio_i) |-> !pulse_o);

endmodule

// File: rtl/dws_pattern.sv
module dws_pattern #(
  parameter int unsigned            CODE_W   = dws_pkg::DEF_CODE_W,
  parameter logic [CODE_W-1:0]      SEL_CODE = dws_pkg::DEF_SEL_CODE
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic dio_i,
  input  logic arm_i,
  output logic hit_o
);
  logic [CODE_W-1:0] sh_q, sh_d;

  // Bits arrive LSB first: new bit enters at the top and moves down.
  for (genvar i = 0; i < CODE_W; i++) begin : g_stage
    if (i == CODE_W - 1) begin : g_top
      assign sh_d[i] = dio_i;
    end else begin : g_mid
      assign sh_d[i] = sh_q[i+1];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) sh_q <= '0;
    else       sh_q <= sh_d;
  end

  assign hit_o = arm_i && (sh_d == SEL_CODE);

  p_hit_last_bit_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    hit_o |-> (dio_i == SEL_CODE[CODE_W-1]));

endmodule

// File: rtl/dws_mode_ctrl.sv
module dws_mode_ctrl (
  input  logic clk_i,
  input  logic rst_i,
  input  logic lr_i,
  input  logic hit_i,
  output logic armed_o,
  output logic mode_o,
  output logic ready_o
);
  import dws_pkg::*;

  link_state_e state_q, state_d;
  logic        armed_q, armed_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LS_SCAN:     if (hit_i) state_d = LS_WAIT_RST;
      LS_WAIT_RST: if (lr_i)  state_d = LS_READY;
      LS_READY:    state_d = LS_READY;
      default:     state_d = LS_SCAN;
    endcase
  end

  always_comb begin
    if (state_q != LS_SCAN) armed_d = 1'b0;
    else if (hit_i)         armed_d = 1'b0;
    else if (lr_i)          armed_d = 1'b1;
    else                    armed_d = armed_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= LS_SCAN;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
    end
  end

  assign armed_o = armed_q;
  assign mode_o  = (state_q != LS_SCAN);
  assign ready_o = (state_q == LS_READY);

  p_reset_flags_r8: assert property (@(posedge clk_i)
    rst_i |=> (!mode_o && !ready_o && !armed_o));

  p_switch_needs_arm_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(mode_o) |-> $past(armed_o));

  p_ready_on_reset_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(ready_o) |-> $past(lr_i) && $past(mode_o));

  p_mode_sticky_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    mode_o |=> mode_o);

  p_ready_sticky_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    ready_o |=> ready_o);

endmodule

// File: rtl/dbg_wire_select.sv
module dbg_wire_select #(
  parameter int unsigned       RUN_LEN  = dws_pkg::DEF_RUN_LEN,
  parameter int unsigned       CODE_W   = dws_pkg::DEF_CODE_W,
  parameter logic [CODE_W-1:0] SEL_CODE = dws_pkg::DEF_SEL_CODE
) (
  input  logic tck_i,
  input  logic rst_i,
  input  logic dio_i,
  output logic wire_mode_o,
  output logic line_rst_o,
  output logic link_ready_o
);
  logic lr_evt;
  logic code_hit;
  logic armed;

  dws_run_detect #(.RUN_LEN(RUN_LEN)) u_run (
    .clk_i   (tck_i),
    .rst_i   (rst_i),
    .dio_i   (dio_i),
    .evt_o   (lr_evt),
    .pulse_o (line_rst_o)
  );

  dws_pattern #(.CODE_W(CODE_W), .SEL_CODE(SEL_CODE)) u_pat (
    .clk_i (tck_i),
    .rst_i (rst_i),
    .dio_i (dio_i),
    .arm_i (armed),
    .hit_o (code_hit)
  );

  dws_mode_ctrl u_ctrl (
    .clk_i   (tck_i),
    .rst_i   (rst_i),
    .lr_i    (lr_evt),
    .hit_i   (code_hit),
    .armed_o (armed),
    .mode_o  (wire_mode_o),
    .ready_o (link_ready_o)
  );

  p_reset_outputs_r1: assert property (@(posedge tck_i)
    rst_i |=> (!wire_mode_o && !link_ready_o && !line_rst_o));

  p_switch_on_code_end_r4: assert property (@(posedge tck_i) disable iff (rst_i)
    $rose(wire_mode_o) |-> ($past(dio_i) == SEL_CODE[CODE_W-1]));

  p_ready_with_pulse_r6: assert property (@(posedge tck_i) disable iff (rst_i)
    $rose(link_ready_o) |-> line_rst_o);

endmodule

// File: tb/tb_dbg_wire_select.sv
module tb_dbg_wire_select;
  logic tck = 1'b0;
  logic rst = 1'b1;
  logic dio = 1'b0;
  logic wire_mode_o, line_rst_o, link_ready_o;

  int n_chk = 0;
  int n_bad = 0;
  int pulses = 0;

  localparam logic [15:0] CODE = 16'h79E7;

  dbg_wire_select dut (
    .tck_i        (tck),
    .rst_i        (rst),
    .dio_i        (dio),
    .wire_mode_o  (wire_mode_o),
    .line_rst_o   (line_rst_o),
    .link_ready_o (link_ready_o)
  );

  always #4 tck = ~tck;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic b);
    @(negedge tck);
    dio = b;
    @(posedge tck);
    #1;
    if (line_rst_o) pulses++;
  endtask

  task automatic ones(input int n);
    for (int i = 0; i < n; i++) push(1'b1);
  endtask

  task automatic send_code(input logic [15:0] c, input int nbits);
    for (int i = 0; i < nbits; i++) push(c[i]);
  endtask

  task automatic do_reset();
    @(negedge tck);
    rst = 1'b1;
    dio = 1'b0;
    @(posedge tck);
    @(posedge tck);
    #1;
    @(negedge tck);
    rst = 1'b0;
    pulses = 0;
  endtask

  task automatic t_reset();
    @(negedge tck); rst = 1'b1; dio = 1'b1;
    @(posedge tck); #1;
    chk("R1 mode after reset", int'(wire_mode_o), 0);
    chk("R1 ready after reset", int'(link_ready_o), 0);
    chk("R1 pulse after reset", int'(line_rst_o), 0);
    do_reset();
  endtask

  task automatic t_line_reset();
    do_reset();
    ones(49);
    chk("R2 no pulse after 49 ones", pulses, 0);
    push(1'b1);
    chk("R2 pulse after 50th one", int'(line_rst_o), 1);
    push(1'b1);
    chk("R2 pulse lasts one cycle", int'(line_rst_o), 0);
  endtask

  task automatic t_break();
    do_reset();
    ones(49);
    push(1'b0);
    ones(49);
    chk("R3 broken run gives no pulse", pulses, 0);
    push(1'b1);
    chk("R3 pulse after fresh run of 50", int'(line_rst_o), 1);
  endtask

  task automatic t_saturate();
    do_reset();
    ones(200);
    chk("R9 one pulse for 200 ones", pulses, 1);
  endtask

  task automatic t_no_arm();
    do_reset();
    send_code(CODE, 16);
    chk("R5 code without line reset ignored", int'(wire_mode_o), 0);
    ones(50);
    send_code(16'h79E6, 16);
    chk("R5 wrong code ignored", int'(wire_mode_o), 0);
    push(1'b0);
    send_code(CODE, 15);
    chk("R4 no switch after 15 bits", int'(wire_mode_o), 0);
    send_code(CODE >> 15, 1);
    chk("R4 switch after 16th bit (armed through junk)", int'(wire_mode_o), 1);
  endtask

  task automatic t_ready();
    do_reset();
    ones(50);
    send_code(CODE, 16);
    chk("R4 switched after armed code", int'(wire_mode_o), 1);
    chk("R6 not ready right after switch", int'(link_ready_o), 0);
    ones(30);
    push(1'b0);
    ones(49);
    chk("R6 not ready after short runs", int'(link_ready_o), 0);
    push(1'b1);
    chk("R6 ready rises with pulse", int'(link_ready_o), 1);
    chk("R6 pulse in same cycle as ready", int'(line_rst_o), 1);
    send_code(16'h0000, 16);
    send_code(CODE, 16);
    ones(60);
    chk("R7 mode sticky", int'(wire_mode_o), 1);
    chk("R7 ready sticky", int'(link_ready_o), 1);
  endtask

  task automatic t_midrst();
    @(negedge tck); rst = 1'b1; dio = 1'b0;
    @(posedge tck); #1;
    chk("R8 mode cleared by reset", int'(wire_mode_o), 0);
    chk("R8 ready cleared by reset", int'(link_ready_o), 0);
    @(negedge tck); rst = 1'b0;
    send_code(CODE, 16);
    chk("R8 matcher disarmed by reset", int'(wire_mode_o), 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge tck);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_line_reset();
    t_break();
    t_saturate();
    t_no_arm();
    t_ready();
    t_midrst();
    finish_run();
  end

endmodule